// File: doc/BRIEF.md
# Clock-Master Serial Word Receiver

This block receives serial words on a single data line while generating the serial clock itself. When the port is enabled, reception begins under one of two controls. A one-shot control collects exactly one word and then drops by itself. A continuous control keeps collecting words until software clears it. Each word is 8 bits, or 9 bits when the wide mode is selected. Bits arrive least-significant first and are sampled at each falling edge of the generated clock.

A completed word is placed in a single holding register. When that happens, a ready flag is raised, and an interrupt line follows the flag when interrupts are enabled. Reading the word clears the flag. If a word completes while the previous one is still unread, the new word is dropped and an overrun flag is raised. The clock is produced from the system clock through a programmable half-period divider. Its resting level is chosen by a polarity input.

Top module: `sm_rx_master`

## Requirements
- R1: With `cfg_en` low, or with neither `once_set`-armed one-shot nor `cont_en` active, the serial clock stays at its resting level and no word completes.
- R2: A `once_set` pulse arms the one-shot control (`once_busy` = 1). Exactly one word is then received, `once_busy` returns to 0 at that word's completion, and the clock then rests.
- R3: While `cont_en` is high, words are received back to back. Clearing `cont_en` in mid-word stops the clock at its resting level, and that partial word is never delivered.
- R4: When both controls are active, continuous reception governs and `once_busy` stays 1. After `cont_en` is cleared, the armed one-shot still delivers one more word and then clears.
- R5: `sdat` is sampled at each falling edge of `sclk`, LSB first. A word takes exactly 8 falling edges, or 9 when `cfg_nine` is 1.
- R6: While no word is in progress, `sclk` rests at `cfg_cpol` (0 = rests low, 1 = rests high).
- R7: With `cfg_nine` = 1, the ninth received bit appears on `rx_bit9`, and the first eight bits appear on `rx_data[7:0]`. With `cfg_nine` = 0, `rx_bit9` is 0.
- R8: `rx_flag` rises when a word is stored, and `rx_data`/`rx_bit9` hold that word unchanged until it is read. A one-cycle `rd_strobe` clears `rx_flag`.
- R9: `rx_irq` equals `rx_flag` when `cfg_ie` is 1, and is 0 when `cfg_ie` is 0.
- R10: A word that completes while `rx_flag` is set and no read is happening is discarded, and `ovr_err` rises. A high-to-low transition of `cont_en` clears `ovr_err`.
- R11: Each `sclk` half-period lasts `cfg_div`+1 system clock cycles, so consecutive falling edges inside a word are 2·(`cfg_div`+1) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable as clock master |
| cfg_cpol | input | 1 | Resting level of the serial clock |
| cfg_nine | input | 1 | 9-bit word mode |
| cfg_ie | input | 1 | Receive interrupt enable |
| cfg_div | input | DIV_W | Half-period length minus one, in clk cycles |
| once_set | input | 1 | One-cycle pulse that arms one-shot reception |
| cont_en | input | 1 | Continuous reception enable (level) |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| sdat | input | 1 | Serial data line |
| sclk | output | 1 | Generated serial clock |
| once_busy | output | 1 | One-shot control currently armed |
| rx_data | output | DATA_W | Received data bits |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_flag | output | 1 | Word ready in the holding register |
| rx_irq | output | 1 | Receive interrupt |
| ovr_err | output | 1 | Overrun error |

## Verification
The bench builds the block with DATA_W = 8 and DIV_W = 4. The narrow divider lets random runs cover the whole divider range, from the shortest half-period (`cfg_div` = 0) to the longest (15), while every word still finishes within a few hundred cycles. At `cfg_div` = 0 the back-to-back continuous words arrive fast enough to drive the overrun path and the both-controls-active ordering directly. Both clock polarities and both word widths are drawn at random, so the case where a falling edge coincides with the start of a word is covered as well as the case where it falls mid-bit.

// File: rtl/sm_rx_pkg.sv
package sm_rx_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } seq_st_t;
endpackage

// File: rtl/sm_rx_div.sv
module sm_rx_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R11
  half_len_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $stable(div)) |-> (cnt <= div));
endmodule

// File: rtl/sm_rx_seq.sv
module sm_rx_seq
  import sm_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            cpol,
  input  logic            nine,
  input  logic            tick,
  input  logic            sdat,
  output logic            run,
  output logic            sclk,
  output logic            done,
  output logic [DATA_W:0] word
);
  localparam int HALVES = 2 * (DATA_W + 1);
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST_WIDE   = HW'(HALVES - 1);
  localparam logic [HW-1:0] LAST_NARROW = HW'(2 * DATA_W - 1);

  seq_st_t         st;
  logic [HW-1:0]   hk;
  logic [HW-1:0]   nxt;
  logic [DATA_W:0] shreg;
  logic            nlvl;
  logic            last_hit;

  assign nxt      = hk + 1'b1;
  assign nlvl     = ~nxt[0] ^ cpol;
  assign last_hit = (hk == (nine ? LAST_WIDE : LAST_NARROW));
  assign run      = (st == ST_RUN);
  assign word     = nine ? shreg : {1'b0, shreg[DATA_W:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      hk    <= '0;
      sclk  <= 1'b0;
      done  <= 1'b0;
      shreg <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          sclk <= cpol;
          hk   <= '0;
          if (go && !done) begin
            st   <= ST_RUN;
            sclk <= ~cpol;
            if (cpol) shreg <= {sdat, shreg[DATA_W:1]};
          end
        end
        ST_RUN: begin
          if (!go) begin
            st   <= ST_IDLE;
            sclk <= cpol;
          end else if (tick) begin
            if (last_hit) begin
              st   <= ST_IDLE;
              sclk <= cpol;
              done <= 1'b1;
            end else begin
              hk   <= nxt;
              sclk <= nlvl;
              if (!nlvl) shreg <= {sdat, shreg[DATA_W:1]};
            end
          end
        end
      endcase
    end
  end

  // R5
  half_index_chk: assert property (@(posedge clk) disable iff (rst)
    hk <= LAST_WIDE);

  // R1
  run_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> !run);
endmodule

// File: rtl/sm_rx_hold.sv
module sm_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W:0]   word,
  input  logic              rd,
  input  logic              ie,
  input  logic              cont,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              flag,
  output logic              irq,
  output logic              ovr
);
  logic cont_q;
  logic flag_n;
  logic accept;
  logic clash;

  assign clash  = done && flag && !rd;
  assign accept = done && !clash;

  always_comb begin
    flag_n = flag;
    if (rd)     flag_n = 1'b0;
    if (accept) flag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q <= 1'b0;
      flag   <= 1'b0;
      irq    <= 1'b0;
      ovr    <= 1'b0;
      data   <= '0;
      bit9   <= 1'b0;
    end else begin
      cont_q <= cont;
      flag   <= flag_n;
      irq    <= flag_n & ie;
      if (accept) begin
        data <= word[DATA_W-1:0];
        bit9 <= word[DATA_W];
      end
      if (clash)                ovr <= 1'b1;
      else if (cont_q && !cont) ovr <= 1'b0;
    end
  end

  // R8
  held_word_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && $past(flag) && !$past(rd)) |-> ($stable(data) && $stable(bit9)));

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R10
  ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> flag);
endmodule

// File: rtl/sm_rx_master.sv
module sm_rx_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_nine,
  input  logic              cfg_ie,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              once_set,
  input  logic              cont_en,
  input  logic              rd_strobe,
  input  logic              sdat,
  output logic              sclk,
  output logic              once_busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              rx_irq,
  output logic              ovr_err
);
  logic            once_q;
  logic            go;
  logic            run;
  logic            tick;
  logic            done;
  logic [DATA_W:0] word;

  assign go        = cfg_en && (cont_en || once_q);
  assign once_busy = once_q;

  always_ff @(posedge clk) begin
    if (rst)                   once_q <= 1'b0;
    else if (once_set)         once_q <= 1'b1;
    else if (done && !cont_en) once_q <= 1'b0;
  end

  sm_rx_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (cfg_div),
    .tick (tick)
  );

  sm_rx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .cpol (cfg_cpol),
    .nine (cfg_nine),
    .tick (tick),
    .sdat (sdat),
    .run  (run),
    .sclk (sclk),
    .done (done),
    .word (word)
  );

  sm_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .done (done),
    .word (word),
    .rd   (rd_strobe),
    .ie   (cfg_ie),
    .cont (cont_en),
    .data (rx_data),
    .bit9 (rx_bit9),
    .flag (rx_flag),
    .irq  (rx_irq),
    .ovr  (ovr_err)
  );

  // R2
  once_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (once_q && done && !cont_en && !once_set) |=> !once_q);

  // R6
  rest_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run) && !$past(rst) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));
endmodule

// File: tb/test_sm_rx_master.sv
module test_sm_rx_master;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              cfg_en = 0, cfg_cpol = 0, cfg_nine = 0, cfg_ie = 0;
  logic [DIV_W-1:0]  cfg_div = '0;
  logic              once_set = 0, cont_en = 0, rd_strobe = 0, sdat = 0;
  logic              sclk, once_busy, rx_bit9, rx_flag, rx_irq, ovr_err;
  logic [DATA_W-1:0] rx_data;

  sm_rx_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_sm_rx_master (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_nine(cfg_nine),
    .cfg_ie(cfg_ie), .cfg_div(cfg_div), .once_set(once_set), .cont_en(cont_en),
    .rd_strobe(rd_strobe), .sdat(sdat), .sclk(sclk), .once_busy(once_busy),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag), .rx_irq(rx_irq),
    .ovr_err(ovr_err)
  );

  int n_run = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk_eq(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // serial data source: advances one bit per observed falling edge of sclk
  logic [8:0] tx_q [4];
  int  tx_i = 0, bit_i = 0, nb = 8, cyc = 0, last_fall = 0, fall_gap = 0;
  logic sclk_prev = 1'b0;
  bit  snd_rst = 0;

  always @(negedge clk) begin
    cyc++;
    if (snd_rst) begin
      tx_i  = 0;
      bit_i = 0;
    end else if (sclk_prev && !sclk) begin
      fall_gap  = cyc - last_fall;
      last_fall = cyc;
      bit_i++;
      if (bit_i >= nb) begin
        bit_i = 0;
        tx_i  = (tx_i + 1) % 4;
      end
    end
    sclk_prev = sclk;
    sdat = tx_q[tx_i][bit_i];
  end

  function automatic int exp_data(logic [8:0] w);
    return int'(w[7:0]);
  endfunction

  function automatic int exp_b9(logic [8:0] w, logic nine);
    return int'(nine & w[8]);
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setup(logic cp, logic nn, int dv, logic ie);
    cfg_cpol = cp; cfg_nine = nn; cfg_div = DIV_W'(dv); cfg_ie = ie;
    nb = nn ? 9 : 8;
    step(2);
    snd_rst = 1; step(); snd_rst = 0; step();
  endtask

  task automatic wait_flag(string req);
    repeat (3000) if (!rx_flag) step();
    if (!rx_flag) chk_eq(req, "flag timeout", 0, 1);
  endtask

  task automatic do_read();
    rd_strobe = 1; step(); rd_strobe = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) tx_q[i] = '0;
    step(3);
    rst = 0;
    step();

    // reset state
    chk_eq("R8", "flag after reset", rx_flag, 0);
    chk_eq("R10", "ovr after reset", ovr_err, 0);
    chk_eq("R9", "irq after reset", rx_irq, 0);
    chk_eq("R2", "once_busy after reset", once_busy, 0);
    chk_eq("R6", "sclk rest low", sclk, 0);

    // R6 resting level follows polarity
    cfg_cpol = 1; step(3);
    chk_eq("R6", "sclk rest high", sclk, 1);
    cfg_cpol = 0; step(3);
    chk_eq("R6", "sclk rest low again", sclk, 0);

    // R1 port disabled: no clock activity, no word
    cont_en = 1; step(60);
    chk_eq("R1", "sclk while disabled", sclk, 0);
    chk_eq("R1", "flag while disabled", rx_flag, 0);
    cont_en = 0;
    cfg_en = 1;
    step(20);
    chk_eq("R1", "sclk with no control", sclk, 0);

    // random one-shot words
    for (int it = 0; it < 14; it++) begin
      logic cp, nn, ie;
      int dv;
      logic [8:0] w;
      cp = 1'($urandom_range(0, 1)); nn = 1'($urandom_range(0, 1));
      ie = 1'($urandom_range(0, 1));
      dv = (it == 0) ? 0 : (it == 1) ? 15 : int'($urandom_range(0, 15));
      w  = 9'($urandom_range(0, 511));
      tx_q[0] = w;
      setup(cp, nn, dv, ie);
      once_set = 1; step(); once_set = 0;
      chk_eq("R2", "once armed", once_busy, 1);
      wait_flag("R8");
      chk_eq("R5", "data lsb-first", rx_data, exp_data(w));
      chk_eq("R7", "ninth bit", rx_bit9, exp_b9(w, nn));
      chk_eq("R9", "irq follows ie", rx_irq, ie);
      chk_eq("R2", "once cleared", once_busy, 0);
      chk_eq("R11", "fall spacing", fall_gap, 2 * (dv + 1));
      step(40);
      chk_eq("R2", "clock rests after one word", sclk, cp);
      chk_eq("R5", "falling edges per word", tx_i * 16 + bit_i, 16);
      do_read();
      chk_eq("R8", "read clears flag", rx_flag, 0);
      chk_eq("R9", "irq drops on read", rx_irq, 0);
    end

    // R3 continuous back-to-back with reads
    for (int i = 0; i < 4; i++) tx_q[i] = 9'($urandom_range(0, 511));
    setup(1, 1, 0, 1);
    cont_en = 1;
    for (int k = 0; k < 3; k++) begin
      wait_flag("R3");
      chk_eq("R3", "continuous word", rx_data, exp_data(tx_q[k]));
      chk_eq("R7", "continuous ninth bit", rx_bit9, exp_b9(tx_q[k], 1'b1));
      do_read();
    end
    cont_en = 0;
    step(2);
    chk_eq("R3", "clock stops on clear", sclk, 1);
    step(60);
    chk_eq("R3", "partial word dropped", rx_flag, 0);

    // R10 overrun
    for (int i = 0; i < 4; i++) tx_q[i] = 9'($urandom_range(0, 511));
    tx_q[1] = tx_q[0] ^ 9'h0ff;
    setup(0, 0, 0, 0);
    cont_en = 1;
    wait_flag("R10");
    chk_eq("R10", "first word held", rx_data, exp_data(tx_q[0]));
    repeat (3000) if (!ovr_err) step();
    chk_eq("R10", "overrun raised", ovr_err, 1);
    chk_eq("R10", "new word discarded", rx_data, exp_data(tx_q[0]));
    chk_eq("R10", "flag kept", rx_flag, 1);
    cont_en = 0; step();
    chk_eq("R10", "overrun cleared by cont fall", ovr_err, 0);
    do_read();

    // R4 both controls active
    for (int i = 0; i < 4; i++) tx_q[i] = 9'($urandom_range(0, 511));
    setup(0, 0, 1, 0);
    cont_en = 1;
    once_set = 1; step(); once_set = 0;
    wait_flag("R4");
    chk_eq("R4", "first word", rx_data, exp_data(tx_q[0]));
    do_read();
    chk_eq("R4", "one-shot stays armed", once_busy, 1);
    wait_flag("R4");
    chk_eq("R4", "continuous governs", rx_data, exp_data(tx_q[1]));
    do_read();
    cont_en = 0;
    wait_flag("R4");
    chk_eq("R4", "pending one-shot word", rx_data, exp_data(tx_q[2]));
    chk_eq("R4", "one-shot cleared", once_busy, 0);
    do_read();
    step(60);
    chk_eq("R4", "no further word", rx_flag, 0);

    // R3 mid-word abort with polarity high
    setup(1, 0, 3, 0);
    cont_en = 1; step(12);
    cont_en = 0; step(2);
    chk_eq("R3", "abort rests high", sclk, 1);
    step(80);
    chk_eq("R3", "abort delivers nothing", rx_flag, 0);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule